// File: doc/BRIEF.md
# Reseeding Accumulator Test-Pattern Generator

This block is a built-in self-test stimulus source. An adder-based accumulator produces test patterns for a unit under test. A small sequencer walks through an on-chip table of reseeding entries. Each entry gives an addend, an initial state and a run length in clocks. For each entry the state register is loaded with the initial state and the addend is held. The accumulator then adds the addend once per clock, and each state value in turn is offered as a pattern. The total test length is the sum of the run lengths over the table.

The table is fixed at elaboration time through three packed parameter vectors. Entry k occupies bits [k*WIDTH +: WIDTH] of the addend and initial-state vectors, and bits [k*CNT_W +: CNT_W] of the run-length vector. In a second variant, chosen by parameter, every entry uses one shared run length. No per-entry count is then stored, and the run-length vector is ignored.

The sequencer has four states:
- `ST_IDLE`: after reset.
- `ST_FETCH`: one cycle per entry. It reads the table and loads the accumulator.
- `ST_RUN`: patterns are applied.
- `ST_DONE`: the table is exhausted.

It has these transitions:
- IDLE→FETCH and DONE→FETCH on start.
- FETCH→RUN when the run length is non-zero.
- FETCH→FETCH, skipping to the next entry, when the run length is zero and the entry is not the last.
- FETCH→DONE when the run length is zero and the entry is the last.
- RUN→RUN while patterns remain.
- RUN→FETCH after the final pattern of an entry that is not the last.
- RUN→DONE after the final pattern of the last entry.

Top module: `reseed_pattern_gen`

## Requirements
- R1: After reset, `pattern_valid` and `done` are low and remain low until `start` is sampled high.
- R2: A `start` sampled high in the idle or done state begins with entry 0. Entries are taken in ascending index order. Each entry is preceded by exactly one cycle with `pattern_valid` low.
- R3: The first pattern of an entry equals that entry's initial state.
- R4: Each later pattern of the same entry equals the previous pattern plus the entry's addend, modulo 2^WIDTH, with the carry out of the top bit discarded.
- R5: An entry with run length T applies exactly T consecutive patterns with `pattern_valid` high.
- R6: An entry with run length 0 applies no pattern. It costs one cycle with `pattern_valid` low before the next entry, or before done if it is the last entry.
- R7: `done` goes high in the cycle after the last entry's final pattern (or after its skip cycle) and stays high until the next `start`. The number of valid cycles in one run equals the sum of the run lengths.
- R8: A `start` sampled while the sequence is running (fetch or run state) has no effect.
- R9: With the shared-length variant enabled, every entry applies exactly FIXED_RUN_LEN patterns, whatever the run-length vector holds.
- R10: Entry k's addend and initial state are taken from bits [k*WIDTH +: WIDTH] of their vectors, and its run length from bits [k*CNT_W +: CNT_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a pass over the table when idle or done |
| pattern | output | WIDTH | Current accumulator state, the test pattern |
| pattern_valid | output | 1 | High on every cycle that applies a pattern |
| done | output | 1 | High once the table has been exhausted, until the next start |

## Verification
Two functions can fall in the same cycle: the completion of a pass and a new `start` request. In the first case, `start` is raised while the final entry is still being handled (a skipped last entry). In the second, `start` is raised in the done state. The reference model accepts a request only when its per-cycle expectation queue is empty. It therefore predicts that the first request is dropped, with `done` still rising, and that the second restarts at entry 0 with `done` falling. A shared-length instance runs in parallel against the same table, and it is judged by the same model with the run length replaced.

// File: rtl/reseed_pkg.sv
package reseed_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/seed_table.sv
module seed_table #(
    parameter int WIDTH         = 8,
    parameter int CNT_W         = 8,
    parameter int NUM_ENTRIES   = 4,
    parameter int IDX_W         = 2,
    parameter bit FIXED_RUN_EN  = 1'b0,
    parameter int FIXED_RUN_LEN = 16,
    parameter logic [NUM_ENTRIES*WIDTH-1:0] ADDEND_TAB = '0,
    parameter logic [NUM_ENTRIES*WIDTH-1:0] INIT_TAB   = '0,
    parameter logic [NUM_ENTRIES*CNT_W-1:0] RUN_TAB    = '0
) (
    input  logic [IDX_W-1:0] idx,
    output logic [WIDTH-1:0] addend,
    output logic [WIDTH-1:0] init_state,
    output logic [CNT_W-1:0] run_len
);

    logic [WIDTH-1:0] addend_arr [NUM_ENTRIES];
    logic [WIDTH-1:0] init_arr   [NUM_ENTRIES];

    // R10: entry k lives at slice k of each vector
    for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_unpack
        assign addend_arr[k] = ADDEND_TAB[k*WIDTH +: WIDTH];
        assign init_arr[k]   = INIT_TAB[k*WIDTH +: WIDTH];
    end

    assign addend     = addend_arr[idx];
    assign init_state = init_arr[idx];

    if (FIXED_RUN_EN) begin : g_shared_len
        // R9: one length for all entries, no per-entry storage
        localparam logic [CNT_W-1:0] SHARED_LEN = CNT_W'(FIXED_RUN_LEN);
        assign run_len = SHARED_LEN;
    end else begin : g_table_len
        logic [CNT_W-1:0] len_arr [NUM_ENTRIES];
        for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_len
            assign len_arr[k] = RUN_TAB[k*CNT_W +: CNT_W];
        end
        assign run_len = len_arr[idx];
    end

endmodule

// File: rtl/accum_core.sv
module accum_core #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] init_state,
    input  logic [WIDTH-1:0] addend,
    output logic [WIDTH-1:0] acc_state,
    output logic [WIDTH-1:0] addend_held
);

    // R4: sum truncated to WIDTH, carry discarded
    logic [WIDTH-1:0] sum_next;
    assign sum_next = acc_state + addend_held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_state   <= '0;
            addend_held <= '0;
        end else if (load) begin
            acc_state   <= init_state;
            addend_held <= addend;
        end else if (step) begin
            acc_state   <= sum_next;
        end
    end

endmodule

// File: rtl/reseed_fsm.sv
module reseed_fsm
    import reseed_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int IDX_W       = 2,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] run_len,
    output logic [IDX_W-1:0] idx,
    output logic             load,
    output logic             step,
    output logic             pattern_valid,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last_entry;
    logic             len_zero;

    assign last_entry = (idx_q == LAST_IDX);
    assign len_zero   = (run_len == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_d = ST_FETCH;
                    idx_d   = '0;
                end
            end
            ST_FETCH: begin
                if (!len_zero) begin
                    state_d = ST_RUN;
                    cnt_d   = run_len - 1'b1;
                end else if (last_entry) begin
                    state_d = ST_DONE;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_RUN: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (last_entry) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_FETCH;
                    idx_d   = idx_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load          = 1'b0;
        step          = 1'b0;
        pattern_valid = 1'b0;
        done          = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: load = !len_zero;
            ST_RUN: begin
                pattern_valid = 1'b1;
                step          = (cnt_q != '0);
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    assign idx = idx_q;

    // R6
    skip_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && len_zero) |=> (state_q != ST_RUN));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R8
    run_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cnt_q != '0) |=> (state_q == ST_RUN && idx_q == $past(idx_q)));

    // R2
    restart_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE || state_q == ST_DONE) && start) |=> (state_q == ST_FETCH && idx_q == '0));

endmodule

// File: rtl/reseed_pattern_gen.sv
module reseed_pattern_gen #(
    parameter int WIDTH         = 8,
    parameter int CNT_W         = 8,
    parameter int NUM_ENTRIES   = 4,
    parameter bit FIXED_RUN_EN  = 1'b0,
    parameter int FIXED_RUN_LEN = 16,
    parameter logic [NUM_ENTRIES*WIDTH-1:0] ADDEND_TAB = {8'h01, 8'h35, 8'h9B, 8'h17},
    parameter logic [NUM_ENTRIES*WIDTH-1:0] INIT_TAB   = {8'h00, 8'hC4, 8'h5E, 8'hA1},
    parameter logic [NUM_ENTRIES*CNT_W-1:0] RUN_TAB    = {8'd12, 8'd20, 8'd0, 8'd9}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [WIDTH-1:0] pattern,
    output logic             pattern_valid,
    output logic             done
);

    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    logic [IDX_W-1:0] idx;
    logic [WIDTH-1:0] addend;
    logic [WIDTH-1:0] init_state;
    logic [CNT_W-1:0] run_len;
    logic             load;
    logic             step;
    logic [WIDTH-1:0] addend_held;

    seed_table #(
        .WIDTH(WIDTH), .CNT_W(CNT_W), .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W),
        .FIXED_RUN_EN(FIXED_RUN_EN), .FIXED_RUN_LEN(FIXED_RUN_LEN),
        .ADDEND_TAB(ADDEND_TAB), .INIT_TAB(INIT_TAB), .RUN_TAB(RUN_TAB)
    ) u_table (
        .idx(idx), .addend(addend), .init_state(init_state), .run_len(run_len)
    );

    reseed_fsm #(
        .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .run_len(run_len),
        .idx(idx), .load(load), .step(step),
        .pattern_valid(pattern_valid), .done(done)
    );

    accum_core #(
        .WIDTH(WIDTH)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .init_state(init_state), .addend(addend),
        .acc_state(pattern), .addend_held(addend_held)
    );

    // R3
    first_is_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pattern_valid) |-> (pattern == init_state));

    // R4
    step_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_valid && $past(pattern_valid)) |-> (pattern == WIDTH'($past(pattern) + $past(addend_held))));

    // R1
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pattern_valid && done));

endmodule

// File: tb/reseed_pattern_gen_bench.sv
module reseed_pattern_gen_bench;

    localparam int CLK_P = 10;
    localparam int W     = 8;
    localparam int CW    = 6;
    localparam int N     = 5;
    localparam int SHARED = 3;

    // bench table: idx 0..4
    localparam logic [W-1:0]  T_ADD  [N] = '{8'h01, 8'h30, 8'h7F, 8'h00, 8'hC3};
    localparam logic [W-1:0]  T_INIT [N] = '{8'hFE, 8'hF0, 8'h10, 8'hAA, 8'h5A};
    localparam logic [CW-1:0] T_RUN  [N] = '{6'd4, 6'd3, 6'd0, 6'd2, 6'd0};

    function automatic logic [N*W-1:0] pack_w(input bit sel_init);
        logic [N*W-1:0] v = '0;
        for (int k = 0; k < N; k++) v[k*W +: W] = sel_init ? T_INIT[k] : T_ADD[k];
        return v;
    endfunction

    function automatic logic [N*CW-1:0] pack_run();
        logic [N*CW-1:0] v = '0;
        for (int k = 0; k < N; k++) v[k*CW +: CW] = T_RUN[k];
        return v;
    endfunction

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] pat0, pat1;
    logic         val0, val1, dn0, dn1;

    always #(CLK_P/2) clk = ~clk;

    reseed_pattern_gen #(
        .WIDTH(W), .CNT_W(CW), .NUM_ENTRIES(N), .FIXED_RUN_EN(1'b0),
        .ADDEND_TAB(pack_w(1'b0)), .INIT_TAB(pack_w(1'b1)), .RUN_TAB(pack_run())
    ) u_reseed_pattern_gen (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pattern(pat0), .pattern_valid(val0), .done(dn0)
    );

    reseed_pattern_gen #(
        .WIDTH(W), .CNT_W(CW), .NUM_ENTRIES(N), .FIXED_RUN_EN(1'b1), .FIXED_RUN_LEN(SHARED),
        .ADDEND_TAB(pack_w(1'b0)), .INIT_TAB(pack_w(1'b1)), .RUN_TAB(pack_run())
    ) u_reseed_pattern_gen_shared (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pattern(pat1), .pattern_valid(val1), .done(dn1)
    );

    typedef struct {
        bit           v;
        bit           d;
        logic [W-1:0] p;
        string        tag;
    } exp_t;

    exp_t q0[$];
    exp_t q1[$];
    bit   fin0 = 1'b0, fin1 = 1'b0;
    int   n_chk = 0, n_bad = 0;
    int   valid_seen = 0;

    function automatic void plan(input int inst);
        exp_t e;
        for (int k = 0; k < N; k++) begin
            logic [W-1:0] acc = T_INIT[k];
            int len = (inst == 1) ? SHARED : int'(T_RUN[k]);
            e = '{v:1'b0, d:1'b0, p:'0, tag:(len == 0) ? "R6" : "R2"};
            if (inst == 0) q0.push_back(e); else q1.push_back(e);
            for (int j = 0; j < len; j++) begin
                e = '{v:1'b1, d:1'b0, p:acc, tag:(j == 0) ? ((inst == 1) ? "R9/R3" : "R3/R10") : ((inst == 1) ? "R9/R4" : "R4/R5")};
                if (inst == 0) q0.push_back(e); else q1.push_back(e);
                acc = acc + T_ADD[k];
            end
        end
        e = '{v:1'b0, d:1'b1, p:'0, tag:"R7"};
        if (inst == 0) begin q0.push_back(e); fin0 = 1'b1; end
        else begin q1.push_back(e); fin1 = 1'b1; end
    endfunction

    task automatic compare(input int inst, input bit v, input bit d, input logic [W-1:0] p);
        exp_t e;
        bit   empty = (inst == 0) ? (q0.size() == 0) : (q1.size() == 0);
        if (empty) e = '{v:1'b0, d:((inst == 0) ? fin0 : fin1), p:'0, tag:(((inst == 0) ? fin0 : fin1) ? "R7" : "R1")};
        else if (inst == 0) e = q0.pop_front();
        else e = q1.pop_front();
        n_chk++;
        if (v !== e.v) begin
            n_bad++;
            $display("FAIL %s inst%0d valid actual %0b expected %0b", e.tag, inst, v, e.v);
        end
        n_chk++;
        if (d !== e.d) begin
            n_bad++;
            $display("FAIL %s inst%0d done actual %0b expected %0b", e.tag, inst, d, e.d);
        end
        if (e.v) begin
            n_chk++;
            if (p !== e.p) begin
                n_bad++;
                $display("FAIL %s inst%0d pattern actual %02h expected %02h", e.tag, inst, p, e.p);
            end
        end
    endtask

    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n) begin
            compare(0, val0, dn0, pat0);
            compare(1, val1, dn1, pat1);
            if (val0) valid_seen++;
        end
    end

    // caller is at a falling edge; request accepted only where the model is idle or done (R8)
    task automatic pulse_start();
        if (q0.size() == 0) begin plan(0); valid_seen = 0; end
        if (q1.size() == 0) plan(1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_empty();
        while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: outputs low in reset
        repeat (3) @(negedge clk);
        n_chk++;
        if (val0 !== 1'b0 || dn0 !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset valid/done actual %0b%0b expected 00", val0, dn0);
        end
        rst_n = 1'b1;
        repeat (4) @(negedge clk);      // R1 idle cycles compared by model

        pulse_start();                  // R2 first pass
        repeat (5) @(negedge clk);
        pulse_start();                  // R8 ignored mid-run
        wait_empty();
        n_chk++;                        // R7 sum of run lengths = 4+3+0+2+0
        if (valid_seen != 9) begin
            n_bad++;
            $display("FAIL R7 valid cycles actual %0d expected %0d", valid_seen, 9);
        end
        repeat (4) @(negedge clk);      // R7 done held

        pulse_start();                  // R2 restart from done
        while (q0.size() != 1) @(negedge clk);
        pulse_start();                  // R8 start during final skipped entry
        wait_empty();
        repeat (3) @(negedge clk);
        n_chk++;
        if (dn0 !== 1'b1) begin
            n_bad++;
            $display("FAIL R7 done after second pass actual %0b expected 1", dn0);
        end
        finish_run();
    end

endmodule